// File: doc/BRIEF.md
# I2C Controller Status Flags and Interrupt Request

This block holds the event flags of an I2C bus controller and combines them into one interrupt request line. The bus engine, which is outside this block, supplies strobes and levels: arbitration lost while sending as master, a valid STOP seen on the wire, the end of each SCL bit cycle with its position in the byte, the acknowledge bit sampled from the bus, the bus-busy level, a strobe for software asking for master mode, and a level that is high while this device is addressed as a slave after it has acknowledged. The block keeps an arbitration-lost flag, a STOP-detected flag, a transfer-complete flag and the last received acknowledge bit. Each of the three flags has an interrupt enable.

Software uses a small register port with two locations: a control register at address 0 and a status register at address 1. Flags are cleared by writing 0 and are left alone by writing 1. A read that belongs to a read-modify-write access returns 1 in the arbitration-lost and STOP positions, so that writing the value back clears nothing by accident. The transfer-complete point can be moved between the 8th and the 9th SCL cycle. This lets a driver take an early interrupt and then a second one once the acknowledge bit is valid.

Top module: `i2c_stat_irq`

## Requirements
- R1: A pulse on `ev_arb_lost` sets the arbitration-lost flag, which is status bit 0, on the next clock edge.
- R2: A `mst_req` pulse sets the arbitration-lost flag when `bus_busy` is 1 and `slave_acked` is 0. The flag is not set when `bus_busy` is 0 or when `slave_acked` is 1.
- R3: Writing the status register with bit 0 = 0 clears the arbitration-lost flag only while `bus_busy` is 0. Writing the status register with bit 2 = 0 clears the arbitration-lost flag whatever the value of `bus_busy`.
- R4: Writing 1 to any status bit has no effect. A status read with `reg_rmw` = 1 returns 1 in bits 0 and 1, whatever the state of those flags. A read with `reg_rmw` = 0 returns the true values.
- R5: The arbitration-lost request is active only while both the flag and its enable (control bit 0) are 1.
- R6: A pulse on `ev_stop` sets the STOP flag (status bit 1) only while `bus_busy` is 1. Writing 0 to status bit 1 clears it. Its request needs control bit 1.
- R7: Control bit 3 selects the completion point. When it is 1, an `ev_bit_end` with `bit_idx` = 8 sets the transfer-complete flag (status bit 2). When it is 0, only `bit_idx` = 9 sets it.
- R8: Status bit 3 takes the value of `ack_rx` on each `ev_bit_end` with `bit_idx` = 9 and holds it at other times. It is read-only.
- R9: Reset clears all flags, the acknowledge bit and the control register. Only a status write with bit 2 = 0 clears the transfer-complete flag. The control register stores bits 3:0, and bits 7:4 read as 0. Reads of any other address return 0.
- R10: If a hardware set event and a software clear of the same flag happen in the same clock, the flag ends up at 1.
- R11: `irq` is 1 exactly when at least one flag is 1 together with its enable. Its enable bits are control bit 0 for arbitration lost, control bit 1 for STOP and control bit 2 for transfer complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_arb_lost | input | 1 | Arbitration lost during master send (pulse) |
| ev_stop | input | 1 | Valid STOP condition seen (pulse) |
| ev_bit_end | input | 1 | End of one SCL bit cycle (pulse) |
| bit_idx | input | 4 | Position of the finished SCL cycle in the byte, 1 to 9 |
| ack_rx | input | 1 | Acknowledge level sampled from the bus |
| bus_busy | input | 1 | Bus busy level |
| slave_acked | input | 1 | Device has acknowledged as an addressed slave |
| mst_req | input | 1 | Software requested master mode (pulse) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Current read belongs to a read-modify-write access |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, 0 when no read |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a hardware set and a software clear of the same flag landing in the same clock edge. The bench brings this about by driving `ev_arb_lost` in the same cycle as a status write with bit 0 = 0 while the bus is idle. It then does the same with `ev_stop` and a STOP clear. A second hard case is the clear of the arbitration-lost flag that goes through transfer-complete while the bus is still busy. The stimulus first shows that a direct clear is refused while `bus_busy` is high, and then shows the indirect clear taking effect. The two-stage completion is followed the way a driver uses it: take the 8th-cycle event, switch the selection bit, then read the acknowledge bit after the 9th cycle.

// File: rtl/i2c_si_pkg.sv
package i2c_si_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;

  // status bit positions
  localparam int S_ARB  = 0;
  localparam int S_STOP = 1;
  localparam int S_XFER = 2;
  localparam int S_ACK  = 3;
  // control bit positions
  localparam int C_ARB_EN  = 0;
  localparam int C_STOP_EN = 1;
  localparam int C_XFER_EN = 2;
  localparam int C_AT8     = 3;
  localparam int CTRL_W    = 4;

  typedef struct packed {
    logic arb;
    logic stop;
    logic xfer;
  } flags_t;

  // SCL cycle number at which transfer completion is flagged
  function automatic logic [CNT_W-1:0] xfer_point(input logic at8);
    return at8 ? CNT_W'(8) : CNT_W'(9);
  endfunction

  // next value of a set-wins flag
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // status word as seen by a read; rmw forces the write-0-clear bits high
  function automatic logic [DATA_W-1:0] stat_word(input flags_t f, input logic ack,
                                                  input logic rmw);
    logic [DATA_W-1:0] w;
    w = '0;
    w[S_ARB]  = f.arb  | rmw;
    w[S_STOP] = f.stop | rmw;
    w[S_XFER] = f.xfer;
    w[S_ACK]  = ack;
    return w;
  endfunction
endpackage

// File: rtl/i2c_si_events.sv
module i2c_si_events
  import i2c_si_pkg::*;
#(
  parameter int CW = CNT_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_arb_lost,
  input  logic          ev_stop,
  input  logic          ev_bit_end,
  input  logic [CW-1:0] bit_idx,
  input  logic          bus_busy,
  input  logic          slave_acked,
  input  logic          mst_req,
  input  logic          at8,
  output logic          arb_set,
  output logic          stop_set,
  output logic          xfer_set,
  output logic          ack_cap
);
  logic [CW-1:0] done_pt;
  logic          req_clash;

  assign done_pt   = CW'(xfer_point(at8));
  assign req_clash = mst_req & bus_busy & ~slave_acked;
  assign arb_set   = ev_arb_lost | req_clash;
  assign stop_set  = ev_stop & bus_busy;
  assign xfer_set  = ev_bit_end & (bit_idx == done_pt);
  assign ack_cap   = ev_bit_end & (bit_idx == CW'(9));

  AST_STOP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_set |-> bus_busy); // R6
  AST_SLAVE_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_acked && !ev_arb_lost) |-> !arb_set); // R2
endmodule

// File: rtl/i2c_si_flags.sv
module i2c_si_flags
  import i2c_si_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              bus_busy,
  input  logic              ack_rx,
  input  logic              arb_set,
  input  logic              stop_set,
  input  logic              xfer_set,
  input  logic              ack_cap,
  output flags_t            flags,
  output logic              last_ack,
  output logic [CTRL_W-1:0] ctrl
);
  logic wr_ctrl, wr_stat;
  logic xfer_clr, arb_clr, stop_clr, arb_clr_blocked;
  logic unused_wbits;

  assign wr_ctrl  = reg_we & (reg_addr == A_CTRL);
  assign wr_stat  = reg_we & (reg_addr == A_STAT);
  assign xfer_clr = wr_stat & ~reg_wdata[S_XFER];
  assign stop_clr = wr_stat & ~reg_wdata[S_STOP];
  assign arb_clr_blocked = wr_stat & ~reg_wdata[S_ARB] & bus_busy;
  assign arb_clr  = (wr_stat & ~reg_wdata[S_ARB] & ~bus_busy) | xfer_clr;
  assign unused_wbits = &{1'b0, reg_wdata[DW-1:CTRL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      last_ack <= 1'b0;
      ctrl     <= '0;
    end else begin
      flags.arb  <= flag_next(flags.arb,  arb_set,  arb_clr);
      flags.stop <= flag_next(flags.stop, stop_set, stop_clr);
      flags.xfer <= flag_next(flags.xfer, xfer_set, xfer_clr);
      if (ack_cap) last_ack <= ack_rx;
      if (wr_ctrl) ctrl <= reg_wdata[CTRL_W-1:0];
    end
  end

  AST_ARB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    arb_set |=> flags.arb); // R1
  AST_ARB_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.arb && arb_clr_blocked && !xfer_clr) |=> flags.arb); // R3
  AST_XFER_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.xfer && !xfer_clr) |=> flags.xfer); // R9
  AST_STOP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_set && stop_clr) |=> flags.stop); // R10
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_cap |=> $stable(last_ack)); // R8
endmodule

// File: rtl/i2c_si_rdmux.sv
module i2c_si_rdmux
  import i2c_si_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
)(
  input  logic              reg_re,
  input  logic              reg_rmw,
  input  logic [AW-1:0]     reg_addr,
  input  flags_t            flags,
  input  logic              last_ack,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0]     reg_rdata
);
  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      unique case (reg_addr)
        A_CTRL:  reg_rdata = DW'(ctrl);
        A_STAT:  reg_rdata = stat_word(flags, last_ack, reg_rmw);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_comb begin
    if (reg_re && reg_rmw && reg_addr == A_STAT)
      AST_RMW_ONES: assert (reg_rdata[S_ARB] && reg_rdata[S_STOP]); // R4
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_si_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_arb_lost,
  input  logic          ev_stop,
  input  logic          ev_bit_end,
  input  logic [CW-1:0] bit_idx,
  input  logic          ack_rx,
  input  logic          bus_busy,
  input  logic          slave_acked,
  input  logic          mst_req,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic          reg_rmw,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  flags_t            flags;
  logic              last_ack;
  logic [CTRL_W-1:0] ctrl;
  logic arb_set, stop_set, xfer_set, ack_cap;
  logic req_arb, req_stop, req_xfer;

  i2c_si_events #(.CW(CW)) u_ev (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(ev_arb_lost), .ev_stop(ev_stop), .ev_bit_end(ev_bit_end),
    .bit_idx(bit_idx), .bus_busy(bus_busy), .slave_acked(slave_acked),
    .mst_req(mst_req), .at8(ctrl[C_AT8]),
    .arb_set(arb_set), .stop_set(stop_set), .xfer_set(xfer_set), .ack_cap(ack_cap)
  );

  i2c_si_flags #(.AW(AW), .DW(DW)) u_fl (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bus_busy(bus_busy), .ack_rx(ack_rx),
    .arb_set(arb_set), .stop_set(stop_set), .xfer_set(xfer_set), .ack_cap(ack_cap),
    .flags(flags), .last_ack(last_ack), .ctrl(ctrl)
  );

  i2c_si_rdmux #(.AW(AW), .DW(DW)) u_rd (
    .reg_re(reg_re), .reg_rmw(reg_rmw), .reg_addr(reg_addr),
    .flags(flags), .last_ack(last_ack), .ctrl(ctrl), .reg_rdata(reg_rdata)
  );

  assign req_arb  = flags.arb  & ctrl[C_ARB_EN];
  assign req_stop = flags.stop & ctrl[C_STOP_EN];
  assign req_xfer = flags.xfer & ctrl[C_XFER_EN];
  assign irq      = req_arb | req_stop | req_xfer;

  AST_IRQ_QUIET_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[C_ARB_EN] == 1'b0 && ctrl[C_STOP_EN] == 1'b0 && ctrl[C_XFER_EN] == 1'b0) |-> !irq); // R11
  AST_IRQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq); // R5
endmodule

// File: tb/tb_i2c_stat_irq.sv
module tb_i2c_stat_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ev_arb_lost = 0, ev_stop = 0, ev_bit_end = 0, ack_rx = 0;
  logic [3:0] bit_idx = 0;
  logic bus_busy = 0, slave_acked = 0, mst_req = 0;
  logic reg_we = 0, reg_re = 0, reg_rmw = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_irq dut (.*);

  // vector: {is_read, rmw, addr[1:0], wdata[7:0], exp[7:0]}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 8'h0F, 8'h00},  // write ctrl
    {1'b1, 1'b0, 2'd0, 8'h00, 8'h0F},  // R9 ctrl readback
    {1'b0, 1'b0, 2'd0, 8'hA5, 8'h00},
    {1'b1, 1'b0, 2'd0, 8'h00, 8'h05},  // R9 upper bits 0
    {1'b0, 1'b0, 2'd1, 8'hFF, 8'h00},  // write 1s to status
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h00},  // R4 no effect
    {1'b1, 1'b1, 2'd1, 8'h00, 8'h03},  // R4 rmw view
    {1'b1, 1'b0, 2'd2, 8'h00, 8'h00}   // R9 unused address
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] d);
    reg_re = 1; reg_addr = a; reg_rmw = rmw; #1;
    d = reg_rdata;
    reg_re = 0; reg_rmw = 0;
  endtask

  task automatic bit_end(input logic [3:0] idx, input logic ack);
    @(negedge clk); ev_bit_end = 1; bit_idx = idx; ack_rx = ack;
    @(negedge clk); ev_bit_end = 0;
  endtask

  task automatic pulse_arb();
    @(negedge clk); ev_arb_lost = 1; @(negedge clk); ev_arb_lost = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask

  task automatic pulse_mreq();
    @(negedge clk); mst_req = 1; @(negedge clk); mst_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd1, 0, d); chk("R9 reset status", d, 8'h00);
    rd(2'd0, 0, d); chk("R9 reset ctrl", d, 8'h00);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        @(negedge clk);
        rd(VEC[i][17:16], VEC[i][18], d);
        chk($sformatf("R4/R9 vector %0d", i), d, VEC[i][7:0]);
      end else wr(VEC[i][17:16], VEC[i][15:8]);
    end
    wr(2'd0, 8'h00);

    // R1, R5
    pulse_arb();
    rd(2'd1, 0, d); chk("R1 arb set", d, 8'h01);
    chk("R5 no irq without enable", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R5 irq with enable", {7'd0, irq}, 8'h01);
    // R3 blocked while busy, then cleared when idle
    bus_busy = 1;
    wr(2'd1, 8'hFE);
    rd(2'd1, 0, d); chk("R3 clear refused while busy", d, 8'h01);
    bus_busy = 0;
    wr(2'd1, 8'hFE);
    rd(2'd1, 0, d); chk("R3 clear when idle", d, 8'h00);
    chk("R11 irq drops", {7'd0, irq}, 8'h00);

    // R2
    bus_busy = 1; slave_acked = 1;
    pulse_mreq();
    rd(2'd1, 0, d); chk("R2 no set after slave ack", d, 8'h00);
    slave_acked = 0; bus_busy = 0;
    pulse_mreq();
    rd(2'd1, 0, d); chk("R2 no set on idle bus", d, 8'h00);
    bus_busy = 1;
    pulse_mreq();
    rd(2'd1, 0, d); chk("R2 set on busy bus", d, 8'h01);

    // R6
    pulse_stop();
    rd(2'd1, 0, d); chk("R6 stop set when busy", d, 8'h03);
    wr(2'd1, 8'hFD);
    rd(2'd1, 0, d); chk("R6 stop cleared", d, 8'h01);
    bus_busy = 0;
    pulse_stop();
    rd(2'd1, 0, d); chk("R6 stop ignored when idle", d, 8'h01);
    bus_busy = 1;

    // R7, R8: 8th-cycle completion, then 9th
    wr(2'd0, 8'h0C);
    bit_end(4'd7, 1'b0);
    rd(2'd1, 0, d); chk("R7 cycle 7 no completion", d, 8'h01);
    bit_end(4'd8, 1'b0);
    rd(2'd1, 0, d); chk("R7 completion at 8", d, 8'h05);
    chk("R11 irq xfer", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h04);
    // R3 clear via transfer-complete while busy
    wr(2'd1, 8'hFB);
    rd(2'd1, 0, d); chk("R3 xfer clear drops arb while busy", d, 8'h00);
    bit_end(4'd8, 1'b1);
    rd(2'd1, 0, d); chk("R7 no completion at 8 when sel=0", d, 8'h00);
    bit_end(4'd9, 1'b1);
    rd(2'd1, 0, d); chk("R7 R8 completion at 9 with ack", d, 8'h0C);
    bit_end(4'd5, 1'b0);
    rd(2'd1, 0, d); chk("R8 ack held", d, 8'h0C);
    wr(2'd1, 8'hFF);
    rd(2'd1, 0, d); chk("R9 xfer not cleared by 1", d, 8'h0C);
    wr(2'd1, 8'hFB);
    bit_end(4'd9, 1'b0);
    rd(2'd1, 0, d); chk("R8 ack captured low", d, 8'h04);
    wr(2'd1, 8'hFB);
    bus_busy = 0;

    // R10 set wins over clear
    @(negedge clk); ev_arb_lost = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'hFE;
    @(negedge clk); ev_arb_lost = 0; reg_we = 0;
    rd(2'd1, 0, d); chk("R10 arb set wins", d, 8'h01);
    bus_busy = 1;
    @(negedge clk); ev_stop = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'hFD;
    @(negedge clk); ev_stop = 0; reg_we = 0;
    rd(2'd1, 0, d); chk("R10 stop set wins", d, 8'h03);

    // R11 OR of enabled requests
    wr(2'd0, 8'h02);
    chk("R11 stop request alone", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h04);
    chk("R11 unflagged enable only", {7'd0, irq}, 8'h00);
    rd(2'd1, 1, d); chk("R4 rmw read of set flags", d, 8'h03);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule